// File: doc/BRIEF.md
# Edge-Selective Delay and Deglitch Filter

This block holds back chosen transitions of a single input signal by a programmable number of clock cycles. A transition reaches the output only after the input has kept its new level for the whole delay window. Any shorter excursion is dropped completely, so the block doubles as a glitch filter on a noisy level. Transitions whose direction is not chosen go through after a single sampling cycle.

A second mode turns the same hardware into an edge detector. It emits a one-cycle pulse for each chosen input transition. A polarity control inverts whatever the selected mode produces. The block runs on one clock. The delay count, edge choice, mode and polarity are static configuration inputs.

Top module: `edge_delay_filter`

## Requirements
- R1: While reset is asserted and right after it is released with a quiet input, the output equals the polarity control (low when `invertOut` is 0).
- R2: In delay mode, a chosen transition that is first sampled at clock edge k shows on the output at edge k + `delayCount` + 2.
- R3: In delay mode, a chosen transition whose new level is sampled on fewer than `delayCount` + 2 consecutive edges never reaches the output. A level sampled on exactly `delayCount` + 2 edges does pass.
- R4: Every return of the input to the output's current level restarts the delay window. The delay then counts from the next chosen transition.
- R5: In delay mode, a transition that is not chosen appears on the output one edge after the edge that samples it.
- R6: In edge-detect mode (`detectMode` = 1), each chosen transition sampled at edge k gives an output pulse exactly one cycle wide, starting at edge k + 1.
- R7: With `edgeSel` = 2'b00, no transition is chosen. Delay mode then passes both directions with one cycle of latency, and edge-detect mode never pulses.
- R8: `invertOut` = 1 inverts the output in both modes, and it takes effect without waiting for a clock edge.
- R9: `edgeSel` bit 0 chooses rising transitions and bit 1 chooses falling transitions. 2'b11 chooses both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dataIn | input | 1 | Signal to delay or watch |
| delayCount | input | CNT_W | Delay setting; the delay is this value plus two cycles |
| edgeSel | input | 2 | Bit 0 chooses rising, bit 1 chooses falling transitions |
| detectMode | input | 1 | 0 selects delay mode, 1 selects edge-detect mode |
| invertOut | input | 1 | Inverts the output polarity |
| dataOut | output | 1 | Filtered, delayed or pulse output |

## Verification
A hold counter that is not cleared when the input returns shows up as a glitch leaking through, or as a delay that comes out short. This shows within one delay window of the disturbing pulse. A stale sampled or held level makes the output react one cycle late, or not react at all. So each timing check pins the exact edge at which the output may move, and not just whether it moves eventually. In edge-detect mode, a pulse register that is not refreshed stretches the pulse to two or more cycles, and the active-cycle count reveals this on the very next transition.

// File: rtl/edge_delay_pkg.sv
package edge_delay_pkg;

  // Edge choice, bit 0 = rising, bit 1 = falling
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edgeSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadLevel;   // copy sampled level into held level
    logic clearCount;  // zero the hold counter
    logic incCount;    // advance the hold counter
    logic pulseSet;    // detect-mode pulse for next cycle
  } ctrlStrobe_t;

endpackage

// File: rtl/edge_delay_datapath.sv
module edge_delay_datapath
  import edge_delay_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataIn,
  input  logic [CNT_W-1:0]  delayCount,
  input  ctrlStrobe_t       strobe,
  output logic              sampled,
  output logic              heldLevel,
  output logic              pulseQ,
  output logic [CNT_W:0]    runCount,
  output logic              countReached
);

  localparam int RUN_W = CNT_W + 1;

  logic [RUN_W-1:0] holdTarget;

  // The level must be seen delayCount+2 times: once when it is first
  // compared, then delayCount+1 more counted edges.
  assign holdTarget   = {1'b0, delayCount} + RUN_W'(1);
  assign countReached = (runCount >= holdTarget);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampled   <= 1'b0;
      heldLevel <= 1'b0;
      pulseQ    <= 1'b0;
      runCount  <= '0;
    end else begin
      sampled <= dataIn;
      pulseQ  <= strobe.pulseSet;
      if (strobe.loadLevel) begin
        heldLevel <= sampled;
      end
      if (strobe.clearCount) begin
        runCount <= '0;
      end else if (strobe.incCount) begin
        runCount <= runCount + RUN_W'(1);
      end
    end
  end

endmodule

// File: rtl/edge_delay_control.sv
module edge_delay_control
  import edge_delay_pkg::*;
(
  input  logic        sampled,
  input  logic        heldLevel,
  input  logic        countReached,
  input  logic [1:0]  edgeSel,
  input  logic        detectMode,
  output ctrlStrobe_t strobe
);

  edgeSel_e selMode;
  logic     riseOn;
  logic     fallOn;
  logic     differs;
  logic     isRise;
  logic     edgeChosen;

  assign selMode    = edgeSel_e'(edgeSel);
  assign riseOn     = (selMode == EDGE_RISE) || (selMode == EDGE_BOTH);
  assign fallOn     = (selMode == EDGE_FALL) || (selMode == EDGE_BOTH);
  assign differs    = sampled ^ heldLevel;
  assign isRise     = sampled & ~heldLevel;
  assign edgeChosen = isRise ? riseOn : fallOn;

  always_comb begin
    strobe = '0;
    if (detectMode) begin
      // Track the input every cycle; pulse on chosen changes
      strobe.loadLevel  = differs;
      strobe.clearCount = 1'b1;
      strobe.pulseSet   = differs & edgeChosen;
    end else if (!differs) begin
      // Input back at output level: restart the window
      strobe.clearCount = 1'b1;
    end else if (!edgeChosen || countReached) begin
      strobe.loadLevel  = 1'b1;
      strobe.clearCount = 1'b1;
    end else begin
      strobe.incCount = 1'b1;
    end
  end

endmodule

// File: rtl/edge_delay_filter.sv
module edge_delay_filter
  import edge_delay_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dataIn,
  input  logic [CNT_W-1:0] delayCount,
  input  logic [1:0]       edgeSel,
  input  logic             detectMode,
  input  logic             invertOut,
  output logic             dataOut
);

  ctrlStrobe_t     strobe;
  logic            sampled;
  logic            heldLevel;
  logic            pulseQ;
  logic [CNT_W:0]  runCount;
  logic            countReached;

  edge_delay_control u_ctrl (
    .sampled      (sampled),
    .heldLevel    (heldLevel),
    .countReached (countReached),
    .edgeSel      (edgeSel),
    .detectMode   (detectMode),
    .strobe       (strobe)
  );

  edge_delay_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .dataIn       (dataIn),
    .delayCount   (delayCount),
    .strobe       (strobe),
    .sampled      (sampled),
    .heldLevel    (heldLevel),
    .pulseQ       (pulseQ),
    .runCount     (runCount),
    .countReached (countReached)
  );

  assign dataOut = (detectMode ? pulseQ : heldLevel) ^ invertOut;

endmodule

// File: rtl/edge_delay_chk.sv
module edge_delay_chk #(
  parameter int CNT_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            detectMode,
  input logic [1:0]      edgeSel,
  input logic            sampled,
  input logic            heldLevel,
  input logic            countReached,
  input logic            pulseQ,
  input logic [CNT_W:0]  runCount
);

  p_rise_full_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!detectMode && $past(!detectMode) && $past(edgeSel[0]) && $rose(heldLevel))
      |-> $past(countReached));

  p_fall_full_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!detectMode && $past(!detectMode) && $past(edgeSel[1]) && $fell(heldLevel))
      |-> $past(countReached));

  p_window_restart_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!detectMode && (sampled == heldLevel)) |=> (runCount == '0));

  p_unchosen_pass_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!detectMode && (sampled != heldLevel) && !(sampled ? edgeSel[0] : edgeSel[1]))
      |=> (heldLevel == $past(sampled)));

  p_pulse_on_change_r6: assert property (@(posedge clk) disable iff (!rstN)
    (detectMode && $past(detectMode) && pulseQ) |-> $past(sampled != heldLevel));

  p_no_pulse_none_r7: assert property (@(posedge clk) disable iff (!rstN)
    (detectMode && $past(detectMode) && ($past(edgeSel) == 2'b00)) |-> !pulseQ);

endmodule

bind edge_delay_filter edge_delay_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .detectMode   (detectMode),
  .edgeSel      (edgeSel),
  .sampled      (sampled),
  .heldLevel    (heldLevel),
  .countReached (countReached),
  .pulseQ       (pulseQ),
  .runCount     (runCount)
);

// File: tb/tb_edge_delay_filter.sv
module tb_edge_delay_filter;

  localparam int CNT_W = 8;
  localparam int NONE  = 255;

  typedef struct packed {
    int mode;   // 0 delay, 1 detect
    int sel;    // bit0 rise, bit1 fall
    int n;      // delayCount
    int inv;
    int len;    // sampled high cycles
    int first;  // expected first active offset, NONE = never
    int count;  // expected active cycles
  } vec_t;

  localparam vec_t VEC [0:11] = '{
    '{0, 3, 3, 0, 8, 5, 8},     // R2 both, long pulse
    '{0, 3, 3, 0, 5, 5, 5},     // R3 exactly n+2 passes
    '{0, 3, 3, 0, 4, NONE, 0},  // R3 one short is dropped
    '{0, 1, 4, 0, 10, 6, 5},    // R9 rise only, fall passes fast
    '{0, 2, 4, 0, 3, 1, 8},     // R5 fall only, rise passes fast
    '{0, 0, 6, 0, 2, 1, 2},     // R7 none chosen in delay mode
    '{1, 3, 5, 0, 4, 1, 2},     // R6 detect both
    '{1, 1, 5, 0, 4, 1, 1},     // R6 detect rise
    '{1, 2, 5, 0, 4, 5, 1},     // R9 detect fall
    '{1, 0, 5, 0, 4, NONE, 0},  // R7 detect none
    '{0, 3, 0, 0, 1, NONE, 0},  // R3 zero setting, single sample
    '{0, 3, 2, 1, 6, 4, 6}      // R8 inverted output
  };

  localparam string VEC_REQ [0:11] = '{
    "R2", "R3", "R3", "R9", "R5", "R7", "R6", "R6", "R9", "R7", "R3", "R8"
  };

  logic             clk = 1'b0;
  logic             rstN;
  logic             dataIn;
  logic [CNT_W-1:0] delayCount;
  logic [1:0]       edgeSel;
  logic             detectMode;
  logic             invertOut;
  logic             dataOut;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  edge_delay_filter #(.CNT_W(CNT_W)) dut (
    .clk        (clk),
    .rstN       (rstN),
    .dataIn     (dataIn),
    .delayCount (delayCount),
    .edgeSel    (edgeSel),
    .detectMode (detectMode),
    .invertOut  (invertOut),
    .dataOut    (dataOut)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic configure(input int mode, input int sel, input int n, input int inv);
    @(negedge clk);
    dataIn     = 1'b0;
    detectMode = mode[0];
    edgeSel    = sel[1:0];
    delayCount = n[CNT_W-1:0];
    invertOut  = inv[0];
    repeat (4) @(negedge clk);
  endtask

  // Drives a high pulse sampled on len edges, measures output activity
  task automatic runPulse(input int len, input int n, input int inv,
                          output int first, output int active);
    int win;
    win    = len + n + 8;
    first  = NONE;
    active = 0;
    dataIn = 1'b1;
    for (int j = 0; j < win; j++) begin
      @(negedge clk);
      dataIn = (j + 1 < len);
      if ((dataOut ^ inv[0]) == 1'b1) begin
        active++;
        if (first == NONE) first = j;
      end
    end
  endtask

  initial begin
    int first;
    int active;
    rstN       = 1'b0;
    dataIn     = 1'b0;
    delayCount = 8'd3;
    edgeSel    = 2'b11;
    detectMode = 1'b0;
    invertOut  = 1'b0;

    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", "output in reset", int'(dataOut), 0);
    invertOut = 1'b1;
    #1;
    check("R8", "inverted output in reset", int'(dataOut), 1);
    invertOut = 1'b0;
    #1;
    @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "output after reset", int'(dataOut), 0);

    // Vector table
    for (int v = 0; v < 12; v++) begin
      configure(VEC[v].mode, VEC[v].sel, VEC[v].n, VEC[v].inv);
      runPulse(VEC[v].len, VEC[v].n, VEC[v].inv, first, active);
      check(VEC_REQ[v], $sformatf("vector %0d first active offset", v), first, VEC[v].first);
      check(VEC_REQ[v], $sformatf("vector %0d active cycles", v), active, VEC[v].count);
    end

    // R4: a one-sample dip restarts the window
    configure(0, 3, 4, 0);
    first  = NONE;
    dataIn = 1'b1;
    for (int j = 0; j < 15; j++) begin
      @(negedge clk);
      dataIn = (j + 1 != 3);
      if (dataOut && first == NONE) first = j;
    end
    check("R4", "rise after restarted window", first, 10);

    // R3: a one-sample low glitch while output is high is swallowed
    active = 0;
    dataIn = 1'b0;
    for (int j = 0; j < 12; j++) begin
      @(negedge clk);
      dataIn = 1'b1;
      if (!dataOut) active++;
    end
    check("R3", "low cycles from short glitch", active, 0);

    // R8: polarity flips without a clock edge in delay mode
    invertOut = 1'b1;
    #1;
    check("R8", "inverted high level", int'(dataOut), 0);
    invertOut = 1'b0;
    dataIn    = 1'b0;
    repeat (10) @(negedge clk);
    check("R2", "output returns low", int'(dataOut), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule